// File: doc/BRIEF.md
# Flag-Setting Data-Processing ALU

This block carries out one data-processing operation of a 32-bit processor. Each operation has a 4-bit opcode, a first operand, and a second operand that an external shifter has already formed, along with the shifter's carry-out. The block returns a result, a destination write-enable and updated N, Z, C and V flags. It also reports two requests for the surrounding core: one to restore the status register and one to flush the instruction pipeline. The shifter, the register file and the status-register restore logic sit outside this block.

A small state machine controls each operation. In `ST_IDLE` the block accepts an operation when `op_valid` is high and copies every input into registers. The transition to `ST_RESULT` is taken directly when the shift amount was a constant. When the shift amount came from a register, the block first passes through `ST_SHIFT_WAIT` for one internal cycle. `ST_RESULT` presents the outputs for exactly one cycle with `res_valid` high and then returns to `ST_IDLE`. While the state is not `ST_IDLE`, `busy` is high and `op_valid` is ignored.

Top module: `alu_dp_core`

## Requirements
- R1: Opcode encoding 0 AND, 1 EOR, 2 SUB, 3 RSB, 4 ADD, 5 ADC, 6 SBC, 7 RSC, 8 TST, 9 TEQ, A CMP, B CMN, C ORR, D MOV, E BIC, F MVN. The logical results are AND a&b, EOR a^b, ORR a|b, MOV b, BIC a&~b and MVN ~b.
- R2: The arithmetic results are SUB a-b, RSB b-a and ADD a+b, all taken modulo 2^32.
- R3: ADC gives a+b+carry_in. SBC gives a-b-1+carry_in and RSC gives b-a-1+carry_in.
- R4: TST, TEQ, CMP and CMN produce the AND, XOR, difference and sum of the operands. They never raise `rd_we` and always raise `flags_we`, whatever `set_flags` and `dst_is_pc` are.
- R5: When `flags_we` is high, `flag_n` equals result bit 31 and `flag_z` is 1 exactly when the result is zero.
- R6: For arithmetic opcodes, `flag_c` is the adder carry-out, which means no borrow for subtractions. `flag_v` is 1 on signed two's-complement overflow.
- R7: For logical opcodes, `flag_c` equals `shift_carry` and `flag_v` equals `ovf_in`.
- R8: An operation accepted with `reg_shift` = 0 gives `res_valid` one cycle after acceptance. With `reg_shift` = 1 it gives `res_valid` two cycles after acceptance. `res_valid` lasts one cycle and `busy` is high from acceptance until it ends.
- R9: When both `reg_shift` and `a_is_pc` are 1, the first operand is increased by 4 before use. In every other case it is used unchanged.
- R10: For a non-compare opcode with `set_flags` = 1 and `dst_is_pc` = 1, `psr_restore` is raised and `flags_we` stays 0.
- R11: For a non-compare opcode, `rd_we` is 1, `flags_we` equals `set_flags` and `dst_is_pc` = 0, and `flush_req` equals `dst_is_pc`.
- R12: After reset `busy` and `res_valid` are 0. When `res_valid` is 0, all of `rd_we`, `flags_we`, `psr_restore` and `flush_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation offered; taken only while idle |
| opcode | input | 4 | Data-processing opcode (R1 encoding) |
| set_flags | input | 1 | Request a flag update |
| op_a | input | DATA_W | First operand |
| op_b | input | DATA_W | Second operand from the shifter |
| shift_carry | input | 1 | Shifter carry-out |
| carry_in | input | 1 | Current C flag |
| ovf_in | input | 1 | Current V flag |
| reg_shift | input | 1 | Shift amount came from a register |
| dst_is_pc | input | 1 | Destination is the program counter |
| a_is_pc | input | 1 | First operand is the program counter |
| busy | output | 1 | Operation in progress |
| res_valid | output | 1 | Outputs valid this cycle |
| result | output | DATA_W | Operation result |
| rd_we | output | 1 | Destination write-enable |
| flags_we | output | 1 | Flag write-enable |
| flag_n | output | 1 | New N flag |
| flag_z | output | 1 | New Z flag |
| flag_c | output | 1 | New C flag |
| flag_v | output | 1 | New V flag |
| psr_restore | output | 1 | Status register must be restored |
| flush_req | output | 1 | Pipeline flush needed |

## Verification
The bench builds the block with `DATA_W` = 32 and `PC_STEP` = 4. At this width the operands 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF reach the signed-overflow, carry-out and zero-result edges of the adder. The program-counter adjustment can also be checked across a 2^32 wrap. A behavioural model uses 64-bit integer arithmetic and checks every cycle of each operation, which covers both latencies and the one-cycle valid pulse.

// File: rtl/alu_dp_pkg.sv
package alu_dp_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
        OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
        OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
        OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
    } alu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_SHIFT_WAIT = 2'd1,
        ST_RESULT     = 2'd2
    } alu_state_e;

    // Opcodes 8..B update flags only
    function automatic logic op_is_compare(input alu_op_e op);
        return op[3:2] == 2'b10;
    endfunction

    function automatic logic op_is_arith(input alu_op_e op);
        return (op inside {OP_SUB, OP_RSB, OP_ADD, OP_ADC, OP_SBC, OP_RSC,
                           OP_CMP, OP_CMN});
    endfunction

endpackage

// File: rtl/alu_dp_opnd.sv
module alu_dp_opnd #(
    parameter int DATA_W  = 32,
    parameter int PC_STEP = 4
) (
    input  logic [DATA_W-1:0] a_raw,
    input  logic              a_is_pc,
    input  logic              reg_shift,
    output logic [DATA_W-1:0] a_eff
);
    localparam logic [DATA_W-1:0] STEP = DATA_W'(PC_STEP);

    always_comb begin
        a_eff = a_raw;
        if (a_is_pc && reg_shift) begin
            a_eff = a_raw + STEP;
        end
    end
endmodule

// File: rtl/alu_dp_adder.sv
module alu_dp_adder
    import alu_dp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic [DATA_W-1:0] sum,
    output logic              cout,
    output logic              ovf
);
    localparam int SUM_W = DATA_W + 1;

    logic [DATA_W-1:0] x, y;
    logic              c0;
    logic [SUM_W-1:0]  total;

    always_comb begin
        x  = a;
        y  = b;
        c0 = 1'b0;
        unique case (op)
            OP_SUB, OP_CMP: begin y = ~b; c0 = 1'b1; end
            OP_RSB:         begin x = b; y = ~a; c0 = 1'b1; end
            OP_ADC:         begin c0 = cin; end
            OP_SBC:         begin y = ~b; c0 = cin; end
            OP_RSC:         begin x = b; y = ~a; c0 = cin; end
            default:        begin c0 = 1'b0; end
        endcase
        total = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, c0};
        sum   = total[DATA_W-1:0];
        cout  = total[DATA_W];
        ovf   = (x[DATA_W-1] == y[DATA_W-1]) && (sum[DATA_W-1] != x[DATA_W-1]);
    end
endmodule

// File: rtl/alu_dp_logic.sv
module alu_dp_logic
    import alu_dp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res
);
    always_comb begin
        unique case (op)
            OP_AND, OP_TST: res = a & b;
            OP_EOR, OP_TEQ: res = a ^ b;
            OP_ORR:         res = a | b;
            OP_MOV:         res = b;
            OP_BIC:         res = a & ~b;
            OP_MVN:         res = ~b;
            default:        res = '0;
        endcase
    end
endmodule

// File: rtl/alu_dp_core.sv
module alu_dp_core
    import alu_dp_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int PC_STEP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        opcode,
    input  logic              set_flags,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              shift_carry,
    input  logic              carry_in,
    input  logic              ovf_in,
    input  logic              reg_shift,
    input  logic              dst_is_pc,
    input  logic              a_is_pc,
    output logic              busy,
    output logic              res_valid,
    output logic [DATA_W-1:0] result,
    output logic              rd_we,
    output logic              flags_we,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_c,
    output logic              flag_v,
    output logic              psr_restore,
    output logic              flush_req
);
    alu_state_e        state_q, state_d;
    alu_op_e           op_q;
    logic [DATA_W-1:0] a_q, b_q;
    logic              set_q, sc_q, cin_q, vin_q, rs_q, dpc_q, apc_q;

    logic              accept;
    logic [DATA_W-1:0] a_eff, arith_res, logic_res, res_w;
    logic              arith_c, arith_v, is_cmp, is_arith;

    assign accept = op_valid && (state_q == ST_IDLE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Operand capture on acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q  <= OP_AND;
            a_q   <= '0;
            b_q   <= '0;
            set_q <= 1'b0;
            sc_q  <= 1'b0;
            cin_q <= 1'b0;
            vin_q <= 1'b0;
            rs_q  <= 1'b0;
            dpc_q <= 1'b0;
            apc_q <= 1'b0;
        end else if (accept) begin
            op_q  <= alu_op_e'(opcode);
            a_q   <= op_a;
            b_q   <= op_b;
            set_q <= set_flags;
            sc_q  <= shift_carry;
            cin_q <= carry_in;
            vin_q <= ovf_in;
            rs_q  <= reg_shift;
            dpc_q <= dst_is_pc;
            apc_q <= a_is_pc;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (op_valid) begin
                    state_d = reg_shift ? ST_SHIFT_WAIT : ST_RESULT;
                end
            end
            ST_SHIFT_WAIT: state_d = ST_RESULT;
            ST_RESULT:     state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    alu_dp_opnd #(.DATA_W(DATA_W), .PC_STEP(PC_STEP)) opnd_i (
        .a_raw     (a_q),
        .a_is_pc   (apc_q),
        .reg_shift (rs_q),
        .a_eff     (a_eff)
    );

    alu_dp_adder #(.DATA_W(DATA_W)) adder_i (
        .op   (op_q),
        .a    (a_eff),
        .b    (b_q),
        .cin  (cin_q),
        .sum  (arith_res),
        .cout (arith_c),
        .ovf  (arith_v)
    );

    alu_dp_logic #(.DATA_W(DATA_W)) logic_i (
        .op  (op_q),
        .a   (a_eff),
        .b   (b_q),
        .res (logic_res)
    );

    assign is_cmp   = op_is_compare(op_q);
    assign is_arith = op_is_arith(op_q);
    assign res_w    = is_arith ? arith_res : logic_res;

    // Output logic
    always_comb begin
        busy        = (state_q != ST_IDLE);
        res_valid   = 1'b0;
        rd_we       = 1'b0;
        flags_we    = 1'b0;
        psr_restore = 1'b0;
        flush_req   = 1'b0;
        result      = res_w;
        flag_n      = res_w[DATA_W-1];
        flag_z      = (res_w == '0);
        flag_c      = is_arith ? arith_c : sc_q;
        flag_v      = is_arith ? arith_v : vin_q;
        unique case (state_q)
            ST_RESULT: begin
                res_valid   = 1'b1;
                rd_we       = !is_cmp;
                flags_we    = is_cmp || (set_q && !dpc_q);
                psr_restore = !is_cmp && set_q && dpc_q;
                flush_req   = !is_cmp && dpc_q;
            end
            default: begin
                res_valid = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/alu_dp_core_chk.sv
module alu_dp_core_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [3:0]        opcode,
    input logic              reg_shift,
    input logic              busy,
    input logic              res_valid,
    input logic [DATA_W-1:0] result,
    input logic              rd_we,
    input logic              flags_we,
    input logic              psr_restore,
    input logic              flush_req
);
    logic taken;
    logic cmp_seen;

    assign taken = op_valid && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_seen <= 1'b0;
        end else if (taken) begin
            cmp_seen <= (opcode[3:2] == 2'b10);
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !(rd_we || flags_we || psr_restore || flush_req)); // R12

    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && cmp_seen) |-> (!rd_we && flags_we)); // R4

    AST_RESTORE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        psr_restore |-> (res_valid && !flags_we)); // R10

    AST_FLUSH_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> rd_we); // R11

    AST_FAST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && !reg_shift) |=> res_valid); // R8

    AST_SLOW_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && reg_shift) |=> (!res_valid && busy) ##1 res_valid); // R8

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R8

    AST_BUSY_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        taken |=> busy); // R8
endmodule

bind alu_dp_core alu_dp_core_chk #(.DATA_W(DATA_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid    (op_valid),
    .opcode      (opcode),
    .reg_shift   (reg_shift),
    .busy        (busy),
    .res_valid   (res_valid),
    .result      (result),
    .rd_we       (rd_we),
    .flags_we    (flags_we),
    .psr_restore (psr_restore),
    .flush_req   (flush_req)
);

// File: tb/alu_dp_core_tb_top.sv
module alu_dp_core_tb_top;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_valid = 1'b0;
    logic [3:0]   opcode = 4'h0;
    logic         set_flags = 1'b0;
    logic [W-1:0] op_a = '0, op_b = '0;
    logic         shift_carry = 1'b0, carry_in = 1'b0, ovf_in = 1'b0;
    logic         reg_shift = 1'b0, dst_is_pc = 1'b0, a_is_pc = 1'b0;
    logic         busy, res_valid, rd_we, flags_we;
    logic         flag_n, flag_z, flag_c, flag_v, psr_restore, flush_req;
    logic [W-1:0] result;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    alu_dp_core #(.DATA_W(W), .PC_STEP(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
        .set_flags(set_flags), .op_a(op_a), .op_b(op_b),
        .shift_carry(shift_carry), .carry_in(carry_in), .ovf_in(ovf_in),
        .reg_shift(reg_shift), .dst_is_pc(dst_is_pc), .a_is_pc(a_is_pc),
        .busy(busy), .res_valid(res_valid), .result(result), .rd_we(rd_we),
        .flags_we(flags_we), .flag_n(flag_n), .flag_z(flag_z),
        .flag_c(flag_c), .flag_v(flag_v), .psr_restore(psr_restore),
        .flush_req(flush_req)
    );

    task automatic check(input string tag, input longint unsigned act,
                         input longint unsigned exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Behavioural reference: 64-bit integer arithmetic per opcode
    task automatic run_op(input int op, input bit sf, input logic [W-1:0] a,
                          input logic [W-1:0] b, input bit sc, input bit ci,
                          input bit vi, input bit rs, input bit dpc,
                          input bit apc);
        longint unsigned two32 = 64'h1_0000_0000;
        longint unsigned ae, x, y, s;
        longint          sx, sy, sv;
        logic [W-1:0]    er;
        bit arith, sub, cin_used, ec, ev, is_cmp, ewe, efwe, erst, efl;
        int lat;
        string rtag;

        ae = a;
        if (rs && apc) ae = (ae + 4) % two32;                  // R9
        arith = 1'b1; sub = 1'b0; cin_used = 1'b0;
        x = ae; y = b;
        case (op)
            2, 10: sub = 1'b1;
            3:  begin sub = 1'b1; x = b; y = ae; end
            4, 11: sub = 1'b0;
            5:  cin_used = 1'b1;
            6:  begin sub = 1'b1; cin_used = 1'b1; end
            7:  begin sub = 1'b1; cin_used = 1'b1; x = b; y = ae; end
            default: arith = 1'b0;
        endcase
        sx = longint'($signed(x[W-1:0]));
        sy = longint'($signed(y[W-1:0]));
        if (arith) begin
            if (sub) begin
                s  = x + two32 - y - ((cin_used && !ci) ? 1 : 0);
                sv = sx - sy - ((cin_used && !ci) ? 1 : 0);
            end else begin
                s  = x + y + ((cin_used && ci) ? 1 : 0);
                sv = sx + sy + ((cin_used && ci) ? 1 : 0);
            end
            er = W'(s % two32);
            ec = (s >= two32);
            ev = (sv > 64'sh7FFF_FFFF) || (sv < -64'sh8000_0000);
        end else begin
            case (op)
                0, 8: er = W'(ae) & b;
                1, 9: er = W'(ae) ^ b;
                12:   er = W'(ae) | b;
                13:   er = b;
                14:   er = W'(ae) & ~b;
                default: er = ~b;
            endcase
            ec = sc; ev = vi;
        end
        is_cmp = (op >= 8 && op <= 11);
        ewe  = !is_cmp;
        efwe = is_cmp || (sf && !dpc);
        erst = !is_cmp && sf && dpc;
        efl  = !is_cmp && dpc;
        lat  = rs ? 2 : 1;
        rtag = !arith ? "R1 logic result" : (cin_used ? "R3 carry-chain result" :
               (is_cmp ? "R4 compare result" : "R2 arith result"));

        @(negedge clk);
        opcode = 4'(op); set_flags = sf; op_a = a; op_b = b;
        shift_carry = sc; carry_in = ci; ovf_in = vi;
        reg_shift = rs; dst_is_pc = dpc; a_is_pc = apc;
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        check("R8 busy after accept", busy, 1);
        for (int cyc = 1; cyc <= lat; cyc++) begin
            if (cyc > 1) @(negedge clk);
            check("R8 res_valid timing", res_valid, (cyc == lat));
            if (cyc < lat)
                check("R12 quiet before valid", {rd_we, flags_we, psr_restore, flush_req}, 0);
        end
        check(rtag, result, er);
        check(is_cmp ? "R4 write-enable" : "R11 write-enable", rd_we, ewe);
        check(is_cmp ? "R4 flag enable" : "R11 flag enable", flags_we, efwe);
        check("R10 restore", psr_restore, erst);
        check("R11 flush", flush_req, efl);
        if (efwe) begin
            check("R5 N flag", flag_n, er[W-1]);
            check("R5 Z flag", flag_z, (er == '0));
            check(arith ? "R6 C flag" : "R7 C flag", flag_c, ec);
            check(arith ? "R6 V flag" : "R7 V flag", flag_v, ev);
        end
        @(negedge clk);
        check("R8 valid one cycle", res_valid, 0);
        check("R8 idle after result", busy, 0);
    endtask

    initial begin
        #(8 * 200000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R12 reset busy", busy, 0);
        check("R12 reset valid", res_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 idle valid", res_valid, 0);

        // R1 and R7: logical opcodes, shifter carry and V passthrough
        run_op(0,  1, 32'hF0F0_1234, 32'h0FF0_FFFF, 1, 0, 1, 0, 0, 0);
        run_op(1,  1, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 0, 1, 0, 0, 0, 0);
        run_op(12, 1, 32'h8000_0000, 32'h0000_0001, 1, 1, 1, 0, 0, 0);
        run_op(13, 1, 32'h1234_5678, 32'h0000_0000, 0, 0, 1, 0, 0, 0);
        run_op(14, 1, 32'hFFFF_FFFF, 32'h0000_FFFF, 1, 0, 0, 0, 0, 0);
        run_op(15, 1, 32'h0,         32'h7FFF_FFFF, 0, 1, 1, 0, 0, 0);
        // R2 and R6: arithmetic boundaries
        run_op(4,  1, 32'h7FFF_FFFF, 32'h0000_0001, 0, 0, 0, 0, 0, 0);
        run_op(4,  1, 32'hFFFF_FFFF, 32'h0000_0001, 0, 0, 0, 0, 0, 0);
        run_op(2,  1, 32'h0000_0005, 32'h0000_0005, 0, 0, 0, 0, 0, 0);
        run_op(2,  1, 32'h0000_0003, 32'h0000_0005, 0, 1, 0, 0, 0, 0);
        run_op(2,  1, 32'h8000_0000, 32'h0000_0001, 0, 0, 0, 0, 0, 0);
        run_op(3,  1, 32'h0000_0010, 32'h0000_0030, 0, 0, 0, 0, 0, 0);
        // R3: carry-in chain, both carry values
        run_op(5,  1, 32'hFFFF_FFFF, 32'h0000_0000, 0, 1, 0, 0, 0, 0);
        run_op(5,  1, 32'h0000_0001, 32'h0000_0001, 0, 0, 0, 0, 0, 0);
        run_op(6,  1, 32'h0000_0005, 32'h0000_0005, 0, 0, 0, 0, 0, 0);
        run_op(6,  1, 32'h0000_0005, 32'h0000_0005, 0, 1, 0, 0, 0, 0);
        run_op(7,  1, 32'h0000_0001, 32'h8000_0000, 0, 0, 0, 0, 0, 0);
        // R4: compares ignore set_flags and dst_is_pc
        run_op(8,  0, 32'h0000_00F0, 32'h0000_000F, 1, 0, 0, 0, 1, 0);
        run_op(9,  0, 32'h1234_5678, 32'h1234_5678, 0, 0, 1, 0, 0, 0);
        run_op(10, 1, 32'h8000_0000, 32'h0000_0001, 0, 0, 0, 0, 1, 0);
        run_op(11, 0, 32'hFFFF_FFFF, 32'h0000_0001, 0, 0, 0, 0, 0, 0);
        // R8 and R9: register-specified shift, program counter first operand
        run_op(4,  1, 32'h0000_1000, 32'h0000_0008, 0, 0, 0, 1, 0, 1);
        run_op(4,  1, 32'hFFFF_FFFC, 32'h0000_0000, 0, 0, 0, 1, 0, 1);
        run_op(4,  1, 32'h0000_1000, 32'h0000_0008, 0, 0, 0, 0, 0, 1);
        run_op(0,  1, 32'h0000_1000, 32'hFFFF_FFFF, 1, 0, 0, 1, 0, 0);
        // R10 and R11: program counter destination and set_flags off
        run_op(13, 1, 32'h0,         32'h0000_0040, 0, 0, 0, 0, 1, 0);
        run_op(2,  0, 32'h0000_0100, 32'h0000_0004, 0, 0, 0, 0, 1, 0);
        run_op(4,  0, 32'h0000_0001, 32'h0000_0002, 0, 0, 0, 0, 0, 0);
        run_op(15, 1, 32'h0,         32'h0,         1, 1, 1, 1, 1, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule